// File: doc/BRIEF.md
# CCD Line Statistics Calculator

This block watches the digitised output of one sensor colour channel for a single line and computes three characterisation figures over the valid pixels: the mean dark level, the dark non-uniformity (the largest distance of any pixel from that mean) and the odd/even register imbalance. Samples arrive as a stream with a start marker on the first sample, a valid strobe and an end marker on the last sample. Results are reported in fixed point together with a one-cycle done pulse.

While the line streams in, a single pass collects the odd-pixel and even-pixel sums, the valid count and the line's extreme values. After the end marker, the mean is formed by multiplying by a fixed-point reciprocal of the line length. The deviation is then taken from the two extremes against that mean, and the imbalance comes from a small serial divider. A line whose valid count differs from the configured length is flagged as an error rather than reported.

Top module: `ccd_line_stats`

## Requirements
- R1: After reset, done_o, err_o and res_valid_o are low and avg_o, dsnu_o and imbal_o are zero.
- R2: A sample is counted only when pix_vld_i is high, either in the cycle with sof_i or in a later cycle up to and including the one with eol_i. Samples with pix_vld_i low, or outside that span, have no effect on any result.
- R3: avg_o is the mean of the N_PIX valid samples with AVG_F fraction bits, rounded half up: (sum·2^AVG_F + N_PIX/2) / N_PIX, integer division.
- R4: dsnu_o is the largest absolute difference between any valid sample scaled by 2^AVG_F and the rounded avg_o value, with AVG_F fraction bits.
- R5: imbal_o is signed with IMB_F fraction bits and equals 200·(S_odd − S_even)·2^IMB_F / S_total, truncated toward zero. S_odd sums the 1st, 3rd, 5th... counted sample of the line, and S_even sums the 2nd, 4th, 6th....
- R6: When the sum of all valid samples is zero, imbal_o is zero.
- R7: If the valid count at the end marker is not exactly N_PIX, done_o still pulses with err_o high, res_valid_o low and all three results zero. Otherwise err_o is low and res_valid_o is high.
- R8: done_o is high for exactly one cycle per finished line. avg_o, dsnu_o, imbal_o, err_o and res_valid_o change only in the cycle where done_o rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Marks the first sample of a line; clears the line state |
| eol_i | input | 1 | Marks the last sample of a line; starts evaluation |
| pix_vld_i | input | 1 | Sample strobe |
| pix_i | input | PIX_W | Unsigned sample |
| done_o | output | 1 | One-cycle pulse when results are updated |
| err_o | output | 1 | Last line had the wrong valid count |
| res_valid_o | output | 1 | Results belong to a correctly sized line |
| avg_o | output | PIX_W+AVG_F | Mean level, unsigned fixed point |
| dsnu_o | output | PIX_W+AVG_F | Peak deviation from the mean, unsigned fixed point |
| imbal_o | output | IMB_F+9 | Odd/even imbalance in percent, signed fixed point |

## Verification
The hardest results to provoke are a negative imbalance at full magnitude and an exact deviation figure when one pixel sits far from an otherwise flat line. Both need the odd and even positions, and the extremes, placed deliberately within the line. The bench therefore uses a short line and sweeps many arithmetic patterns across it: flat lines, ramps, lines that are all-odd or all-even, single spikes and pseudo-random lines. Strobe gaps and stray samples outside the line are mixed into the stream, and lines one sample short or one sample long are included, so the counting and error paths are exercised next to the arithmetic.

// File: rtl/ccd_stat_pkg.sv
package ccd_stat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_DEV  = 2'd2
  } stat_state_e;

  // percentage scale applied to the imbalance ratio, times two for pair mean
  localparam int IMB_SCALE = 200;
  localparam int IMB_SCALE_W = 8;
endpackage

// File: rtl/ccd_stat_accum.sv
module ccd_stat_accum #(
  parameter int PIX_W = 12,
  parameter int N_PIX = 10800,
  parameter int CNT_W = 14,
  parameter int SUM_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof_i,
  input  logic             eol_i,
  input  logic             vld_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             go_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [SUM_W-1:0] sodd_o,
  output logic [SUM_W-1:0] seven_o,
  output logic [PIX_W-1:0] pmin_o,
  output logic [PIX_W-1:0] pmax_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(N_PIX);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(N_PIX + 1);

  logic             in_line_q, in_line_d;
  logic             odd_q, odd_d, odd_b;
  logic             go_q, go_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_b;
  logic [SUM_W-1:0] sodd_q, sodd_d, sodd_b;
  logic [SUM_W-1:0] seven_q, seven_d, seven_b;
  logic [PIX_W-1:0] min_q, min_d, min_b;
  logic [PIX_W-1:0] max_q, max_d, max_b;
  logic             active, hit;

  always_comb begin
    active = sof_i | in_line_q;
    if (sof_i) begin
      odd_b   = 1'b1;
      cnt_b   = '0;
      sodd_b  = '0;
      seven_b = '0;
      min_b   = '1;
      max_b   = '0;
    end else begin
      odd_b   = odd_q;
      cnt_b   = cnt_q;
      sodd_b  = sodd_q;
      seven_b = seven_q;
      min_b   = min_q;
      max_b   = max_q;
    end
    hit     = active & vld_i;
    odd_d   = odd_b;
    cnt_d   = cnt_b;
    sodd_d  = sodd_b;
    seven_d = seven_b;
    min_d   = min_b;
    max_d   = max_b;
    if (hit && (cnt_b != CNT_OVER)) begin
      cnt_d = cnt_b + 1'b1;
    end
    if (hit && (cnt_b < CNT_FULL)) begin
      odd_d = ~odd_b;
      if (odd_b) sodd_d  = sodd_b + SUM_W'(pix_i);
      else       seven_d = seven_b + SUM_W'(pix_i);
      if (pix_i < min_b) min_d = pix_i;
      if (pix_i > max_b) max_d = pix_i;
    end
    in_line_d = eol_i ? 1'b0 : active;
    go_d      = eol_i & active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_line_q <= 1'b0;
      odd_q     <= 1'b1;
      go_q      <= 1'b0;
      cnt_q     <= '0;
      sodd_q    <= '0;
      seven_q   <= '0;
      min_q     <= '1;
      max_q     <= '0;
    end else begin
      in_line_q <= in_line_d;
      odd_q     <= odd_d;
      go_q      <= go_d;
      cnt_q     <= cnt_d;
      sodd_q    <= sodd_d;
      seven_q   <= seven_d;
      min_q     <= min_d;
      max_q     <= max_d;
    end
  end

  assign go_o    = go_q;
  assign cnt_o   = cnt_q;
  assign sodd_o  = sodd_q;
  assign seven_o = seven_q;
  assign pmin_o  = min_q;
  assign pmax_o  = max_q;
endmodule

// File: rtl/ccd_stat_scale.sv
module ccd_stat_scale #(
  parameter int PIX_W = 12,
  parameter int N_PIX = 10800,
  parameter int SUM_W = 26,
  parameter int AVG_F = 4
) (
  input  logic [SUM_W-1:0]       sum_i,
  output logic [PIX_W+AVG_F-1:0] avg_o
);
  localparam int NW    = $clog2(N_PIX + 1);
  localparam int XW    = SUM_W + AVG_F;
  localparam int SH    = XW + NW;
  localparam int PW    = XW + SH + 1;
  localparam int AVG_W = PIX_W + AVG_F;
  // ceil(2^SH / N_PIX): exact floor division for every x below 2^XW
  localparam logic [63:0] MULT = ((64'd1 << SH) + 64'(N_PIX) - 64'd1) / 64'(N_PIX);

  logic [XW-1:0] x;
  logic [PW-1:0] prod;

  always_comb begin
    x     = (XW'(sum_i) << AVG_F) + XW'(N_PIX / 2);
    prod  = PW'(x) * PW'(MULT);
    avg_o = AVG_W'(prod >> SH);
  end
endmodule

// File: rtl/ccd_stat_div.sv
module ccd_stat_div #(
  parameter int NUM_W = 42,
  parameter int DEN_W = 26,
  parameter int Q_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [Q_W-1:0]   quo_o
);
  localparam int CW = $clog2(NUM_W + 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [DEN_W:0]   rem_q, rem_d, rem_sh;
  logic [NUM_W-1:0] q_q, q_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic             ge;

  always_comb begin
    rem_sh = {rem_q[DEN_W-1:0], q_q[NUM_W-1]};
    ge     = rem_sh >= {1'b0, den_q};
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    q_d    = q_q;
    den_d  = den_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      rem_d  = '0;
      q_d    = num_i;
      den_d  = den_i;
    end else if (busy_q) begin
      rem_d = ge ? (rem_sh - {1'b0, den_q}) : rem_sh;
      q_d   = {q_q[NUM_W-2:0], ge};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(NUM_W - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      q_q    <= '0;
      den_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      q_q    <= q_d;
      den_q  <= den_d;
    end
  end

  assign done_o = done_q;
  assign quo_o  = Q_W'(q_q);
endmodule

// File: rtl/ccd_line_stats.sv
module ccd_line_stats
  import ccd_stat_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int N_PIX = 10800,
  parameter int AVG_F = 4,
  parameter int IMB_F = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sof_i,
  input  logic                       eol_i,
  input  logic                       pix_vld_i,
  input  logic [PIX_W-1:0]           pix_i,
  output logic                       done_o,
  output logic                       err_o,
  output logic                       res_valid_o,
  output logic [PIX_W+AVG_F-1:0]     avg_o,
  output logic [PIX_W+AVG_F-1:0]     dsnu_o,
  output logic signed [IMB_F+8:0]    imbal_o
);
  localparam int NW    = $clog2(N_PIX + 1);
  localparam int CNT_W = $clog2(N_PIX + 2);
  localparam int SUM_W = PIX_W + NW;
  localparam int AVG_W = PIX_W + AVG_F;
  localparam int IMB_W = IMB_SCALE_W + IMB_F + 1;
  localparam int NUM_W = SUM_W + IMB_SCALE_W + IMB_F;
  localparam int Q_W   = IMB_W - 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             go;
  logic [CNT_W-1:0] cnt;
  logic [SUM_W-1:0] sodd, seven, sum_all, dmag;
  logic [PIX_W-1:0] pmin, pmax;
  logic [AVG_W-1:0] avg_calc;
  logic             odd_ge, div_start, div_done;
  logic [NUM_W-1:0] div_num;
  logic [Q_W-1:0]   quo;

  ccd_stat_accum #(
    .PIX_W(PIX_W), .N_PIX(N_PIX), .CNT_W(CNT_W), .SUM_W(SUM_W)
  ) accum_i (
    .clk(clk), .rst_n(rst_int_n), .sof_i(sof_i), .eol_i(eol_i),
    .vld_i(pix_vld_i), .pix_i(pix_i), .go_o(go), .cnt_o(cnt),
    .sodd_o(sodd), .seven_o(seven), .pmin_o(pmin), .pmax_o(pmax)
  );

  always_comb begin
    sum_all = sodd + seven;
    odd_ge  = sodd >= seven;
    dmag    = odd_ge ? (sodd - seven) : (seven - sodd);
    div_num = (NUM_W'(dmag) * NUM_W'(IMB_SCALE)) << IMB_F;
  end

  ccd_stat_scale #(
    .PIX_W(PIX_W), .N_PIX(N_PIX), .SUM_W(SUM_W), .AVG_F(AVG_F)
  ) scale_i (
    .sum_i(sum_all), .avg_o(avg_calc)
  );

  ccd_stat_div #(
    .NUM_W(NUM_W), .DEN_W(SUM_W), .Q_W(Q_W)
  ) div_i (
    .clk(clk), .rst_n(rst_int_n), .start_i(div_start), .num_i(div_num),
    .den_i(sum_all), .done_o(div_done), .quo_o(quo)
  );

  stat_state_e             st_q, st_d;
  logic [AVG_W-1:0]        avg_int_q, avg_int_d;
  logic signed [IMB_W-1:0] imb_int_q, imb_int_d;
  logic                    done_q, done_d, err_q, err_d, val_q, val_d;
  logic [AVG_W-1:0]        avg_q, avg_d, dsnu_q, dsnu_d;
  logic signed [IMB_W-1:0] imb_q, imb_d, imb_pos;
  logic [AVG_W-1:0]        dev_hi, dev_lo;

  always_comb begin
    st_d      = st_q;
    avg_int_d = avg_int_q;
    imb_int_d = imb_int_q;
    done_d    = 1'b0;
    err_d     = err_q;
    val_d     = val_q;
    avg_d     = avg_q;
    dsnu_d    = dsnu_q;
    imb_d     = imb_q;
    div_start = 1'b0;
    imb_pos   = $signed({1'b0, quo});
    dev_hi    = (AVG_W'(pmax) << AVG_F) - avg_int_q;
    dev_lo    = avg_int_q - (AVG_W'(pmin) << AVG_F);
    unique case (st_q)
      ST_IDLE: begin
        if (go) begin
          if (cnt != CNT_W'(N_PIX)) begin
            done_d = 1'b1;
            err_d  = 1'b1;
            val_d  = 1'b0;
            avg_d  = '0;
            dsnu_d = '0;
            imb_d  = '0;
          end else begin
            avg_int_d = avg_calc;
            div_start = 1'b1;
            st_d      = ST_DIV;
          end
        end
      end
      ST_DIV: begin
        if (div_done) begin
          if (sum_all == '0) imb_int_d = '0;
          else if (odd_ge)   imb_int_d = imb_pos;
          else               imb_int_d = -imb_pos;
          st_d = ST_DEV;
        end
      end
      ST_DEV: begin
        avg_d  = avg_int_q;
        dsnu_d = (dev_hi > dev_lo) ? dev_hi : dev_lo;
        imb_d  = imb_int_q;
        val_d  = 1'b1;
        err_d  = 1'b0;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q      <= ST_IDLE;
      avg_int_q <= '0;
      imb_int_q <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      val_q     <= 1'b0;
      avg_q     <= '0;
      dsnu_q    <= '0;
      imb_q     <= '0;
    end else begin
      st_q      <= st_d;
      avg_int_q <= avg_int_d;
      imb_int_q <= imb_int_d;
      done_q    <= done_d;
      err_q     <= err_d;
      val_q     <= val_d;
      avg_q     <= avg_d;
      dsnu_q    <= dsnu_d;
      imb_q     <= imb_d;
    end
  end

  assign done_o      = done_q;
  assign err_o       = err_q;
  assign res_valid_o = val_q;
  assign avg_o       = avg_q;
  assign dsnu_o      = dsnu_q;
  assign imbal_o     = imb_q;
endmodule

// File: rtl/ccd_line_stats_chk.sv
module ccd_line_stats_chk #(
  parameter int AVG_W = 16,
  parameter int IMB_W = 17,
  parameter int IMB_F = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    done_o,
  input logic                    err_o,
  input logic                    res_valid_o,
  input logic [AVG_W-1:0]        avg_o,
  input logic [AVG_W-1:0]        dsnu_o,
  input logic signed [IMB_W-1:0] imbal_o
);
  localparam int LIM = 200 << IMB_F;

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_results_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(avg_o) && $stable(dsnu_o) && $stable(imbal_o)
                 && $stable(err_o) && $stable(res_valid_o)));

  assert_err_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!res_valid_o && avg_o == '0 && dsnu_o == '0 && imbal_o == '0));

  assert_good_line_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> res_valid_o);

  assert_imb_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(imbal_o) <= LIM) && (int'(imbal_o) >= -LIM));
endmodule

bind ccd_line_stats ccd_line_stats_chk #(
  .AVG_W(AVG_W), .IMB_W(IMB_W), .IMB_F(IMB_F)
) chk_i (
  .clk(clk), .rst_n(rst_n), .done_o(done_o), .err_o(err_o),
  .res_valid_o(res_valid_o), .avg_o(avg_o), .dsnu_o(dsnu_o),
  .imbal_o(imbal_o)
);

// File: tb/ccd_line_stats_tb_top.sv
module ccd_line_stats_tb_top;
  localparam int PIX_W = 12;
  localparam int NP    = 12;
  localparam int AVG_F = 4;
  localparam int IMB_F = 8;
  localparam int AVG_W = PIX_W + AVG_F;
  localparam int IMB_W = IMB_F + 9;

  logic clk, rst_n, sof, eol, vld;
  logic [PIX_W-1:0] pix;
  logic done_o, err_o, res_valid_o;
  logic [AVG_W-1:0] avg_o, dsnu_o;
  logic signed [IMB_W-1:0] imbal_o;

  int tests, fails;
  int px [0:31];
  int lcg;

  ccd_line_stats #(.PIX_W(PIX_W), .N_PIX(NP), .AVG_F(AVG_F), .IMB_F(IMB_F)) dut_i (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .eol_i(eol), .pix_vld_i(vld),
    .pix_i(pix), .done_o(done_o), .err_o(err_o), .res_valid_o(res_valid_o),
    .avg_o(avg_o), .dsnu_o(dsnu_o), .imbal_o(imbal_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input int n, input bit noisy);
    if (noisy) begin
      for (int g = 0; g < 3; g++) begin
        @(negedge clk); sof = 0; eol = 0; vld = 1; pix = PIX_W'(4095 - g);
      end
    end
    for (int i = 0; i < n; i++) begin
      if (noisy && (i % 3 == 1)) begin
        @(negedge clk); sof = 0; eol = 0; vld = 0; pix = PIX_W'(4095);
      end
      @(negedge clk);
      sof = (i == 0); eol = (i == n - 1); vld = 1; pix = PIX_W'(px[i]);
    end
    @(negedge clk); sof = 0; eol = 0; vld = 0; pix = '0;
    if (noisy) begin
      vld = 1; pix = PIX_W'(4095);
      @(negedge clk); vld = 0; pix = '0;
    end
  endtask

  task automatic run_line(input int n, input bit noisy, input string tag);
    longint so, se, s, av, ds, d, mag, im, e_av, e_ds, e_im;
    bit seen;
    send(n, noisy);
    seen = 0;
    for (int w = 0; w < 300 && !seen; w++) begin
      if (done_o) seen = 1;
      else @(negedge clk);
    end
    chk("R8", {tag, " done pulse seen"}, longint'(seen), 1);
    so = 0; se = 0;
    for (int i = 0; i < n && i < NP; i++) begin
      if (i % 2 == 0) so += px[i]; else se += px[i];
    end
    s  = so + se;
    av = (s * 16 + NP / 2) / NP;
    ds = 0;
    for (int i = 0; i < NP && i < n; i++) begin
      d = longint'(px[i]) * 16 - av;
      if (d < 0) d = -d;
      if (d > ds) ds = d;
    end
    if (s == 0) im = 0;
    else begin
      d = so - se;
      mag = ((d < 0 ? -d : d) * 200 * 256) / s;
      im = (d < 0) ? -mag : mag;
    end
    if (n != NP) begin
      chk("R7", {tag, " err_o"}, longint'(err_o), 1);
      chk("R7", {tag, " res_valid_o"}, longint'(res_valid_o), 0);
      e_av = 0; e_ds = 0; e_im = 0;
    end else begin
      chk("R7", {tag, " err_o"}, longint'(err_o), 0);
      chk("R7", {tag, " res_valid_o"}, longint'(res_valid_o), 1);
      e_av = av; e_ds = ds; e_im = im;
    end
    chk(noisy ? "R2" : "R3", {tag, " avg_o"}, longint'(avg_o), e_av);
    chk("R4", {tag, " dsnu_o"}, longint'(dsnu_o), e_ds);
    chk(s == 0 ? "R6" : "R5", {tag, " imbal_o"}, longint'(imbal_o), e_im);
    @(negedge clk);
    chk("R8", {tag, " done one cycle"}, longint'(done_o), 0);
    repeat (3) @(negedge clk);
    chk("R8", {tag, " results held avg"}, longint'(avg_o), e_av);
  endtask

  initial begin
    tests = 0; fails = 0; lcg = 12345;
    sof = 0; eol = 0; vld = 0; pix = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", "done_o in reset", longint'(done_o), 0);
    chk("R1", "err_o in reset", longint'(err_o), 0);
    chk("R1", "res_valid_o in reset", longint'(res_valid_o), 0);
    chk("R1", "avg_o in reset", longint'(avg_o), 0);
    chk("R1", "imbal_o in reset", longint'(imbal_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "dsnu_o after reset", longint'(dsnu_o), 0);

    for (int i = 0; i < NP; i++) px[i] = 0;
    run_line(NP, 0, "zero line R6");
    for (int i = 0; i < NP; i++) px[i] = 4095;
    run_line(NP, 0, "full scale");
    for (int i = 0; i < NP; i++) px[i] = (i % 2 == 0) ? 4095 : 0;
    run_line(NP, 0, "odd only R5");
    for (int i = 0; i < NP; i++) px[i] = (i % 2 == 0) ? 0 : 4095;
    run_line(NP, 0, "even only R5");
    for (int i = 0; i < NP; i++) px[i] = (i == 7) ? 4095 : 100;
    run_line(NP, 0, "spike R4");
    for (int i = 0; i < NP; i++) px[i] = (i == 4) ? 0 : 3000;
    run_line(NP, 0, "dip R4");
    for (int i = 0; i < NP; i++) px[i] = i * 300 + 7;
    run_line(NP, 1, "ramp gaps R2");
    run_line(NP - 1, 0, "short R7");
    for (int i = 0; i < NP + 1; i++) px[i] = 50 + i;
    run_line(NP + 1, 0, "long R7");
    for (int i = 0; i < NP; i++) px[i] = 9 + (i % 2) * 3;
    run_line(NP, 0, "recover R7");
    for (int k = 1; k < 24; k++) begin
      for (int i = 0; i < NP; i++) px[i] = (k * 173 + i * i * k * 7 + (i % 2) * k * 50) % 4096;
      run_line(NP, (k % 4) == 0, "sweep R3");
    end
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < NP; i++) begin
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        px[i] = (lcg >>> 8) % 4096;
      end
      run_line(NP, k[0], "random R5");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule